// File: doc/BRIEF.md
# Dual-Channel Split-Phase Pulse Generator

This block drives two independent pulse outputs. Each output's waveform is described by two 16-bit tick counts: how long the output stays high and how long it then stays low. The pair repeats as long as the channel runs. Each channel has its own settings. It picks one of four single-cycle source strobes and slows that strobe down with its own 7-bit prescaler. Its phase counter advances once per divided tick.

Software programs the block through a plain synchronous 32-bit register port. There is one duration word per channel and one shared control word. The control word holds, for each channel, the run bit, the tick gate, the source select and the prescaler value. All source strobes share one clock domain with the block. A count of zero removes its phase, so the output can be held constantly high or constantly low without stopping the channel. A new duration written while a channel runs is held back until the running cycle has finished.

Top module: `dual_span_pwm`

## Requirements
- R1: The register port decodes byte addresses on `bus_addr`. Address 0x8 holds the control word, 0x0 holds channel 0's duration word and 0x4 holds channel 1's. In a duration word, bits 31:16 are the high-phase count and bits 15:0 are the low-phase count, and all 32 bits read back as written. Any other address reads as zero, and a write to it changes no register.
- R2: Control word layout: bit 0 runs channel 0 and bit 1 runs channel 1. Bits 5:4 select channel 0's source and bits 7:6 select channel 1's. Bits 14:8 hold channel 0's divider and bits 22:16 hold channel 1's. Bit 15 gates channel 0's ticks and bit 23 gates channel 1's. Bits 3:2 and 31:24 read as zero whatever was written. Every defined field reads back its last written value.
- R3: With divider value N and source select S, each divided tick takes N+1 pulses of `src_tick[S]`. The high phase therefore spans (high count)·(N+1) source pulses.
- R4: A running channel alternates without pause: high for (high count) divided ticks, then low for (low count) divided ticks.
- R5: A high count of zero with a nonzero low count keeps the output low at all times.
- R6: A low count of zero with a nonzero high count keeps the output high at all times once the channel has started.
- R7: When both counts are zero, the output of a running channel stays low.
- R8: A duration write to a running channel does not alter the high or low phase in progress. The new counts apply from the next high phase onward.
- R9: Clearing a channel's run bit drives its output low in the clock after the write is taken, and resets its prescaler and phase counter. Setting the bit again starts a fresh high phase in the clock after that write, so the output is high if the high count is nonzero.
- R10: While a running channel's gate bit is clear, its output holds its level and its sequence does not advance. Once the gate bit is set again, full phases resume.
- R11: The two channels are independent. Each one's output depends only on its own duration word and its own control fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; also the clock of all source strobes |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 4 | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_tick | input | 4 | Four single-cycle source strobes |
| pwm_out | output | 2 | Pulse outputs, bit 0 for channel 0 |

## Verification
The bench builds the block with its package widths: 16-bit phase counts and a 7-bit divider. It drives the four source strobes at periods of 1, 2, 3 and 5 clocks. Because of that, every source select and every divider value gives a different, predictable output width in clocks, computed as count·(N+1)·period. The random configurations use small counts, which keeps whole cycles short enough to measure many of them on both channels at once. A directed case with divider 127 reaches the top of the prescaler range.

// File: rtl/dual_span_pwm_pkg.sv
package dual_span_pwm_pkg;

  localparam int CH_N   = 2;
  localparam int SRC_N  = 4;
  localparam int SEL_W  = $clog2(SRC_N);
  localparam int DIV_W  = 7;
  localparam int CNT_W  = 16;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 4;
  localparam int LANE_W = 8;   // control bits spent per channel in the divider/gate lane

  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(8);
  localparam logic [WORD_W-1:0] CTRL_MASK = 32'h00FF_FFF3;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HIGH,
    PH_LOW,
    PH_HOLD
  } phase_e;

  typedef struct packed {
    logic             run;
    logic             gate;
    logic [SEL_W-1:0] sel;
    logic [DIV_W-1:0] div;
  } chan_cfg_t;

  // byte offset of a channel's duration word
  function automatic logic [ADDR_W-1:0] dur_offset(input int ch);
    return ADDR_W'(4 * ch);
  endfunction

  // pull one channel's fields out of the shared control word
  function automatic chan_cfg_t chan_cfg(input logic [WORD_W-1:0] w, input int ch);
    chan_cfg_t c;
    c.run  = w[ch];
    c.sel  = w[4 + SEL_W*ch +: SEL_W];
    c.div  = w[8 + LANE_W*ch +: DIV_W];
    c.gate = w[8 + DIV_W + LANE_W*ch];
    return c;
  endfunction

  // first phase of a fresh cycle for a given count pair
  function automatic phase_e first_phase(input logic [CNT_W-1:0] hi,
                                         input logic [CNT_W-1:0] lo);
    if (hi != '0)      return PH_HIGH;
    else if (lo != '0) return PH_LOW;
    else               return PH_HOLD;
  endfunction

  // true on the last tick of a phase of length len (len >= 1)
  function automatic logic span_done(input logic [CNT_W-1:0] elapsed,
                                     input logic [CNT_W-1:0] len);
    return elapsed == (len - 1'b1);
  endfunction

  // prescaler wraps once the count reaches the divider value
  function automatic logic prescale_wrap(input logic [DIV_W-1:0] cnt,
                                         input logic [DIV_W-1:0] div);
    return cnt >= div;
  endfunction

endpackage

// File: rtl/dual_span_pwm_regs.sv
module dual_span_pwm_regs
  import dual_span_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [WORD_W-1:0] dur_o [CH_N],
  output logic [WORD_W-1:0] ctrl_o
);

  logic [WORD_W-1:0] dur_q [CH_N];
  logic [WORD_W-1:0] ctrl_q;
  logic              addr_known;

  always_comb begin
    addr_known = (bus_addr == OFF_CTRL);
    for (int c = 0; c < CH_N; c++) begin
      if (bus_addr == dur_offset(c)) addr_known = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      for (int c = 0; c < CH_N; c++) dur_q[c] <= '0;
    end else if (bus_we) begin
      if (bus_addr == OFF_CTRL) ctrl_q <= bus_wdata & CTRL_MASK;
      for (int c = 0; c < CH_N; c++) begin
        if (bus_addr == dur_offset(c)) dur_q[c] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFF_CTRL) bus_rdata = ctrl_q;
    for (int c = 0; c < CH_N; c++) begin
      if (bus_addr == dur_offset(c)) bus_rdata = dur_q[c];
    end
  end

  assign ctrl_o = ctrl_q;
  always_comb for (int c = 0; c < CH_N; c++) dur_o[c] = dur_q[c];

  // R1: a write to an undecoded address leaves every register untouched
  assert_stray_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !addr_known) |=> ($stable(ctrl_q) && $stable(dur_q[0]) && $stable(dur_q[1])));

  // R2: reserved control bits never appear on the read port
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_CTRL) |-> ((bus_rdata & ~CTRL_MASK) == '0));

endmodule

// File: rtl/dual_span_pwm_prescale.sv
module dual_span_pwm_prescale
  import dual_span_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             gate_i,
  input  logic             strobe_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q;
  logic             step;
  logic             wrap;

  assign step   = run_i && gate_i && strobe_i;
  assign wrap   = prescale_wrap(cnt_q, div_i);
  assign tick_o = step && wrap;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  // R3: every divided tick restarts the pulse count
  assert_wrap_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));

  // R10: with the gate closed the prescaler holds its count
  assert_gate_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !gate_i) |=> $stable(cnt_q));

  // R9: a stopped channel keeps its prescaler cleared
  assert_stop_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/dual_span_pwm_seq.sv
module dual_span_pwm_seq
  import dual_span_pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             pwm_o,
  output phase_e           phase_o
);

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] elapsed_q, elapsed_d;
  logic [CNT_W-1:0] hi_q, lo_q;
  logic             load;

  always_comb begin
    phase_d   = phase_q;
    elapsed_d = elapsed_q;
    load      = 1'b0;
    unique case (phase_q)
      PH_IDLE: load = 1'b1;
      PH_HIGH: if (tick_i) begin
        if (span_done(elapsed_q, hi_q)) begin
          elapsed_d = '0;
          if (lo_q != '0) phase_d = PH_LOW;
          else            load    = 1'b1;
        end else begin
          elapsed_d = elapsed_q + 1'b1;
        end
      end
      PH_LOW: if (tick_i) begin
        if (span_done(elapsed_q, lo_q)) load = 1'b1;
        else elapsed_d = elapsed_q + 1'b1;
      end
      PH_HOLD: if (tick_i) load = 1'b1;
      default: load = 1'b1;
    endcase
    if (load) begin
      phase_d   = first_phase(hi_i, lo_i);
      elapsed_d = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      phase_q   <= PH_IDLE;
      elapsed_q <= '0;
      if (!rst_n) begin
        hi_q <= '0;
        lo_q <= '0;
      end
    end else begin
      phase_q   <= phase_d;
      elapsed_q <= elapsed_d;
      if (load) begin
        hi_q <= hi_i;
        lo_q <= lo_i;
      end
    end
  end

  assign pwm_o   = (phase_q == PH_HIGH);
  assign phase_o = phase_q;

  // R9: a cleared run bit pulls the output low one clock later
  assert_stop_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !pwm_o);

  // R5: a high phase is only ever entered with a nonzero latched high count
  assert_high_has_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HIGH) |-> (hi_q != '0));

  // R6: a low phase is only ever entered with a nonzero latched low count
  assert_low_has_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW) |-> (lo_q != '0));

  // R7: the hold state belongs to the all-zero count pair
  assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOLD) |-> (hi_q == '0 && lo_q == '0));

  // R10: without a tick a running sequence does not move
  assert_no_tick_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && $past(run_i) && !tick_i) |=> ($stable(phase_q) && $stable(elapsed_q)));

  // R8: latched counts change only at a cycle boundary
  assert_counts_at_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && phase_q == PH_HIGH && !span_done(elapsed_q, hi_q)) |=> ($stable(hi_q) && $stable(lo_q)));

endmodule

// File: rtl/dual_span_pwm.sv
module dual_span_pwm
  import dual_span_pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [SRC_N-1:0]  src_tick,
  output logic [CH_N-1:0]   pwm_out
);

  logic [WORD_W-1:0] dur_w [CH_N];
  logic [WORD_W-1:0] ctrl_w;

  dual_span_pwm_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .dur_o     (dur_w),
    .ctrl_o    (ctrl_w)
  );

  for (genvar c = 0; c < CH_N; c++) begin : g_chan
    chan_cfg_t cfg;
    logic      strobe;
    logic      div_tick;
    phase_e    phase;

    assign cfg    = chan_cfg(ctrl_w, c);
    assign strobe = src_tick[cfg.sel];

    dual_span_pwm_prescale u_prescale (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (cfg.run),
      .gate_i   (cfg.gate),
      .strobe_i (strobe),
      .div_i    (cfg.div),
      .tick_o   (div_tick)
    );

    dual_span_pwm_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .run_i   (cfg.run),
      .tick_i  (div_tick),
      .hi_i    (dur_w[c][WORD_W-1 -: CNT_W]),
      .lo_i    (dur_w[c][CNT_W-1:0]),
      .pwm_o   (pwm_out[c]),
      .phase_o (phase)
    );

    // R11: an output can only rise while its own channel runs
    assert_rise_needs_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out[c]) |-> $past(cfg.run));
  end

endmodule

// File: tb/test_dual_span_pwm.sv
module test_dual_span_pwm;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  src_tick;
  logic [1:0]  pwm_out;

  int  vectors = 0;
  int  fails   = 0;
  bit  done    = 0;
  int  sc [4]  = '{0, 0, 0, 0};

  always #4 clk = ~clk;

  dual_span_pwm i_dual_span_pwm (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .src_tick  (src_tick),
    .pwm_out   (pwm_out)
  );

  function automatic int per(input int s);
    case (s)
      0: return 1;
      1: return 2;
      2: return 3;
      default: return 5;
    endcase
  endfunction

  initial src_tick = 4'b0000;
  always @(posedge clk) begin
    for (int k = 0; k < 4; k++) begin
      sc[k]       <= (sc[k] + 1 >= per(k)) ? 0 : sc[k] + 1;
      src_tick[k] <= (sc[k] == 0);
    end
  end

  function automatic int span_clocks(input int cnt, input int div, input int sel);
    return cnt * (div + 1) * per(sel);
  endfunction

  function automatic logic [31:0] ctl(input bit ra, input bit ga, input int sa, input int da,
                                      input bit rb, input bit gb, input int sb, input int db);
    logic [31:0] w = '0;
    w[0] = ra; w[1] = rb;
    w[5:4] = 2'(sa); w[7:6] = 2'(sb);
    w[14:8] = 7'(da); w[15] = ga;
    w[22:16] = 7'(db); w[23] = gb;
    return w;
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_level(input int ch, input bit v, inout int guard);
    while (pwm_out[ch] !== v && guard < 6000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic count_level(input int ch, input bit v, inout int guard, output int n);
    n = 0;
    while (pwm_out[ch] === v && guard < 6000) begin
      n++;
      @(negedge clk);
      guard++;
    end
  endtask

  // width of one full high phase and the following low phase, in clocks
  task automatic measure(input int ch, output int hw, output int lw);
    int guard = 0;
    @(negedge clk);
    wait_level(ch, 1'b1, guard);
    wait_level(ch, 1'b0, guard);
    wait_level(ch, 1'b1, guard);
    count_level(ch, 1'b1, guard, hw);
    count_level(ch, 1'b0, guard, lw);
    if (guard >= 6000) begin hw = -1; lw = -1; end
  endtask

  task automatic count_high(input int ch, input int len, output int n);
    n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (pwm_out[ch] === 1'b1) n++;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d0, d1, c;
    int hw, lw, hw2, lw2, n;
    process::self().srandom(32'h5EED_0042);

    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state
    chk("R9 reset output", pwm_out, 0);
    rd(4'h0, d); chk("R1 reset dur0", d, 0);
    rd(4'h4, d); chk("R1 reset dur1", d, 0);
    rd(4'h8, d); chk("R2 reset ctrl", d, 0);

    // register map and readback
    for (int i = 0; i < 6; i++) begin
      d0 = $urandom; d1 = $urandom; c = $urandom & ~32'h3;
      wr(4'h0, d0); wr(4'h4, d1); wr(4'h8, c);
      wr(4'hC, $urandom);
      rd(4'h0, d); chk("R1 dur0 readback", d, d0);
      rd(4'h4, d); chk("R1 dur1 readback", d, d1);
      rd(4'h8, d); chk("R2 ctrl readback", d, c & 32'h00FF_FFF3);
      rd(4'hC, d); chk("R1 unmapped read", d, 0);
    end
    wr(4'h8, 0); wr(4'h0, 0); wr(4'h4, 0);

    // random configurations, both channels running together
    for (int v = 0; v < 12; v++) begin
      int ha = 1 + $urandom_range(0, 5), la = 1 + $urandom_range(0, 5);
      int hb = 1 + $urandom_range(0, 5), lb = 1 + $urandom_range(0, 5);
      int da = $urandom_range(0, 3), db = $urandom_range(0, 3);
      int sa = $urandom_range(0, 3), sb = $urandom_range(0, 3);
      wr(4'h8, 0);
      wr(4'h0, {16'(ha), 16'(la)});
      wr(4'h4, {16'(hb), 16'(lb)});
      wr(4'h8, ctl(1, 1, sa, da, 1, 1, sb, db));
      measure(0, hw, lw);
      chk("R3 ch0 high width", hw, span_clocks(ha, da, sa));
      chk("R4 ch0 low width", lw, span_clocks(la, da, sa));
      measure(1, hw, lw);
      chk("R11 ch1 high width", hw, span_clocks(hb, db, sb));
      chk("R11 ch1 low width", lw, span_clocks(lb, db, sb));
    end

    // largest divider
    wr(4'h8, 0);
    wr(4'h0, {16'd1, 16'd2});
    wr(4'h8, ctl(1, 1, 0, 127, 0, 0, 0, 0));
    measure(0, hw, lw);
    chk("R3 divider 127 high", hw, 128);
    chk("R4 divider 127 low", lw, 256);

    // zero high count
    wr(4'h8, 0);
    wr(4'h0, {16'd0, 16'd5});
    wr(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    count_high(0, 300, n);
    chk("R5 zero high count stays low", n, 0);

    // zero low count
    wr(4'h8, 0);
    wr(4'h0, {16'd5, 16'd0});
    wr(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    count_high(0, 300, n);
    chk("R6 zero low count stays high", n, 300);
    chk("R11 idle ch1 low", pwm_out[1], 0);

    // both zero
    wr(4'h8, 0);
    wr(4'h0, 32'd0);
    wr(4'h8, ctl(1, 1, 1, 2, 0, 0, 0, 0));
    count_high(0, 300, n);
    chk("R7 both counts zero low", n, 0);

    // stop and restart timing
    wr(4'h8, 0);
    wr(4'h0, {16'hFFFF, 16'd1});
    wr(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    @(posedge clk); #1;
    chk("R9 start drives high", pwm_out[0], 1);
    wr(4'h8, ctl(0, 1, 0, 0, 0, 0, 0, 0));
    @(posedge clk); #1;
    chk("R9 stop drives low", pwm_out[0], 0);
    wr(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    @(posedge clk); #1;
    chk("R9 restart high", pwm_out[0], 1);

    // gate freeze
    wr(4'h8, 0);
    wr(4'h0, {16'd50, 16'd50});
    wr(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    repeat (10) @(negedge clk);
    wr(4'h8, ctl(1, 0, 0, 0, 0, 0, 0, 0));
    count_high(0, 300, n);
    chk("R10 gate closed holds level", n, 300);
    wr(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    measure(0, hw, lw);
    chk("R10 resumes full high", hw, 50);

    // duration change in the middle of a cycle
    begin
      int guard = 0;
      wr(4'h8, 0);
      wr(4'h0, {16'd4, 16'd4});
      wr(4'h8, ctl(1, 1, 0, 0, 0, 0, 0, 0));
      @(negedge clk);
      wait_level(0, 1'b1, guard);
      wait_level(0, 1'b0, guard);
      wait_level(0, 1'b1, guard);
      bus_we = 1'b1; bus_addr = 4'h0; bus_wdata = {16'd2, 16'd6};
      hw = 0;
      while (pwm_out[0] === 1'b1 && guard < 6000) begin
        hw++;
        @(negedge clk);
        bus_we = 1'b0;
        guard++;
      end
      count_level(0, 1'b0, guard, lw);
      count_level(0, 1'b1, guard, hw2);
      count_level(0, 1'b0, guard, lw2);
      chk("R8 running high kept", hw, 4);
      chk("R8 running low kept", lw, 4);
      chk("R8 next high new", hw2, 2);
      chk("R8 next low new", lw2, 6);
    end

    wr(4'h8, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule